// File: doc/BRIEF.md
# Paired Vector Register Load Sequencer

This block executes one decoded load-pair operation at a time into a vector register file. It accepts the size selector, a signed 7-bit scaled offset, a base register index and two destination indices. From these it forms the effective address, either from a general register read through a combinational read port or from the stack pointer. It then issues two consecutive reads on a valid/ready memory request port and waits for each response. Last, it writes the two returned values, zero-extended to the full register width, through a single write port.

The block rejects an invalid size code and a misaligned stack pointer. A shared destination register is handled by a policy input. Each operation ends with a one-cycle `done` pulse that carries the fault flags. Every memory request carries a non-temporal hint bit and a tag-check flag so the memory system can act on them.

Top module: `vpair_load_unit`

## Requirements
- R1: `op_size` 0, 1 and 2 select 4-, 8- and 16-byte elements. `mem_size` repeats that code on each request. Each write carries the low 32, 64 or 128 bits of the response, with the upper bits cleared.
- R2: The first request address is the base plus the byte offset. The offset is `op_imm7` sign-extended and shifted left by 2 + `op_size`, so -64 and 63 give -256/252, -512/504 and -1024/1008.
- R3: The second request address is the first address plus the element byte count (4, 8 or 16).
- R4: Base index 31 selects `sp_value`. Any other index reads `gpr_data`, which answers the index shown on `gpr_idx`.
- R5: If the base is 31 and `sp_value` is not a multiple of 16, the operation ends with `flt_align` high at `done`. No memory request is made and no register is written.
- R6: `op_size` 3 ends with `flt_undef` high at `done`, with no request and no write. This check ranks above the shared-destination and alignment checks, and `mem_size` is never 3.
- R7: When `op_dst0` equals `op_dst1`, `cfg_same_dst` sets the outcome. 0 performs both reads and writes all-zero data twice to that register. 1 ends with `flt_undef` and no access. 2 or 3 ends with no fault, no access and no write, even when the stack pointer is misaligned.
- R8: Every memory request has `mem_nt` high. `mem_tagchk` is high exactly when the base is not the stack pointer.
- R9: Only one request is outstanding at a time. The second request follows the first response. The address holds while ready is low. Writes happen only after both responses: first to `op_dst0` with the first data, then to `op_dst1` with the second.
- R10: `op_ready` is high only while idle. Each accepted operation produces exactly one single-cycle `done` pulse, and the fault flags are high only together with `done`.
- R11: After reset, `op_ready` is high and `mem_req_valid`, `vr_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation accepted when valid |
| op_size | input | 2 | Element size code |
| op_imm7 | input | 7 | Signed scaled offset |
| op_base | input | 5 | Base register index, 31 = stack pointer |
| op_dst0 | input | 5 | Destination of first element |
| op_dst1 | input | 5 | Destination of second element |
| cfg_same_dst | input | 2 | Policy when both destinations match |
| gpr_idx | output | 5 | General register read index |
| gpr_data | input | 64 | General register read data |
| sp_value | input | 64 | Stack pointer value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_addr | output | 64 | Request byte address |
| mem_size | output | 2 | Request element size code |
| mem_nt | output | 1 | Non-temporal hint |
| mem_tagchk | output | 1 | Tag-check flag |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_data | input | 128 | Response data |
| vr_we | output | 1 | Vector register write enable |
| vr_idx | output | 5 | Vector register write index |
| vr_data | output | 128 | Vector register write data |
| done | output | 1 | Operation finished pulse |
| flt_align | output | 1 | Stack alignment fault, valid with done |
| flt_undef | output | 1 | Undefined operation fault, valid with done |

## Verification
The bench sweeps the offset to both ends of its range at every element size and compares the two request addresses. A design that skipped sign extension or shifted by the wrong amount would produce addresses far from the expected ones. Stack-pointer bases are run both aligned and misaligned, and an unexpected request or write is flagged on any fault path. Shared destinations are exercised under all three policies, combined with a misaligned stack and an invalid size, so a design that ranked its checks in the wrong order would report the wrong fault or touch memory. The request port stalls on a repeating pattern, so a design that moved the address or issued the second read early would not match the scoreboard.

// File: rtl/vpl_pkg.sv
// Shared types for the paired vector load sequencer.
// Assumes element sizes are powers of two starting at 4 bytes.
package vpl_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_REQ1, S_WAIT1, S_REQ2, S_WAIT2, S_WR1, S_WR2, S_FIN
    } vpl_state_e;

    localparam logic [1:0] SIZE_BAD   = 2'b11;
    localparam logic [4:0] SP_INDEX   = 5'd31;
    localparam int unsigned MIN_SCALE = 2;
endpackage

// File: rtl/vpl_addr_gen.sv
// Effective address generator: picks the base (stack pointer or general
// register), scales the signed offset by element size, and reports the byte
// step and stack misalignment. Purely combinational; assumes opc < 3 when used.
module vpl_addr_gen #(
    parameter int AW       = 64,
    parameter int IMM_W    = 7,
    parameter int SP_ALIGN = 16
) (
    input  logic [1:0]       size,
    input  logic [IMM_W-1:0] imm,
    input  logic [4:0]       base_idx,
    input  logic [AW-1:0]    gpr_val,
    input  logic [AW-1:0]    sp_val,
    output logic             base_is_sp,
    output logic             sp_misaligned,
    output logic [AW-1:0]    addr_first,
    output logic [AW-1:0]    step_bytes
);
    import vpl_pkg::*;
    localparam int ALIGN_BITS = $clog2(SP_ALIGN);

    logic [2:0]    scale;
    logic [AW-1:0] imm_ext;
    logic [AW-1:0] base;

    // Form scale, sign-extended offset and selected base
    always_comb begin
        scale         = 3'(MIN_SCALE) + {1'b0, size};
        imm_ext       = {{(AW-IMM_W){imm[IMM_W-1]}}, imm};
        base_is_sp    = (base_idx == SP_INDEX);
        base          = base_is_sp ? sp_val : gpr_val;
        sp_misaligned = |sp_val[ALIGN_BITS-1:0];
        addr_first    = base + (imm_ext << scale);
        step_bytes    = AW'(1) << scale;
    end
endmodule

// File: rtl/vpl_wdata.sv
// Write-data shaper: keeps the low element bits of a response, clears the
// rest, and forces zero for the shared-destination "zero" policy.
module vpl_wdata #(
    parameter int VW  = 128,
    parameter int NSZ = 3
) (
    input  logic [1:0]    size,
    input  logic          force_zero,
    input  logic [VW-1:0] src,
    output logic [VW-1:0] dst
);
    logic [VW-1:0] lanes [NSZ];

    for (genvar g = 0; g < NSZ; g++) begin : g_lane
        localparam int EW = 32 << g;
        assign lanes[g] = src & VW'({EW{1'b1}});
    end

    // Select the lane for the active size
    always_comb begin
        dst = '0;
        for (int i = 0; i < NSZ; i++)
            if (int'(size) == i) dst = lanes[i];
        if (force_zero) dst = '0;
    end
endmodule

// File: rtl/vpl_ctrl.sv
// Sequencer FSM: accepts one operation, checks it, issues the two reads one
// at a time, holds the data, then writes two registers and pulses done.
// Assumes the memory returns exactly one response per accepted request.
module vpl_ctrl #(
    parameter int AW = 64,
    parameter int VW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_size,
    input  logic [4:0]    op_dst0,
    input  logic [4:0]    op_dst1,
    input  logic [1:0]    cfg_same_dst,
    input  logic          base_is_sp,
    input  logic          sp_misaligned,
    input  logic [AW-1:0] addr_first,
    input  logic [AW-1:0] step_bytes,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [VW-1:0] mem_rsp_data,
    output logic          op_ready,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic          mem_tagchk,
    output logic          vr_we,
    output logic [4:0]    vr_idx,
    output logic [VW-1:0] sel_data,
    output logic          zero_data,
    output logic          done,
    output logic          flt_align,
    output logic          flt_undef
);
    import vpl_pkg::*;

    vpl_state_e    state_q;
    logic [AW-1:0] addr_q, step_q;
    logic [1:0]    size_q;
    logic [4:0]    dst0_q, dst1_q;
    logic          tag_q, zero_q, fa_q, fu_q;
    logic [VW-1:0] d1_q, d2_q;
    logic          same;

    assign same = (op_dst0 == op_dst1);

    // State and operand registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            step_q  <= '0;
            size_q  <= '0;
            dst0_q  <= '0;
            dst1_q  <= '0;
            tag_q   <= 1'b0;
            zero_q  <= 1'b0;
            fa_q    <= 1'b0;
            fu_q    <= 1'b0;
            d1_q    <= '0;
            d2_q    <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (op_valid) begin
                    size_q <= op_size;
                    dst0_q <= op_dst0;
                    dst1_q <= op_dst1;
                    addr_q <= addr_first;
                    step_q <= step_bytes;
                    tag_q  <= !base_is_sp;
                    zero_q <= same;
                    if (op_size == SIZE_BAD) begin
                        fu_q    <= 1'b1;
                        state_q <= S_FIN;
                    end else if (same && cfg_same_dst == 2'd1) begin
                        fu_q    <= 1'b1;
                        state_q <= S_FIN;
                    end else if (same && cfg_same_dst[1]) begin
                        state_q <= S_FIN;
                    end else if (base_is_sp && sp_misaligned) begin
                        fa_q    <= 1'b1;
                        state_q <= S_FIN;
                    end else begin
                        state_q <= S_REQ1;
                    end
                end
                S_REQ1:  if (mem_req_ready) state_q <= S_WAIT1;
                S_WAIT1: if (mem_rsp_valid) begin
                    d1_q    <= mem_rsp_data;
                    addr_q  <= addr_q + step_q;
                    state_q <= S_REQ2;
                end
                S_REQ2:  if (mem_req_ready) state_q <= S_WAIT2;
                S_WAIT2: if (mem_rsp_valid) begin
                    d2_q    <= mem_rsp_data;
                    state_q <= S_WR1;
                end
                S_WR1:   state_q <= S_WR2;
                S_WR2:   state_q <= S_FIN;
                default: begin
                    fa_q    <= 1'b0;
                    fu_q    <= 1'b0;
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    // Decode outputs from state
    always_comb begin
        op_ready      = (state_q == S_IDLE);
        mem_req_valid = (state_q == S_REQ1) || (state_q == S_REQ2);
        mem_addr      = addr_q;
        mem_size      = size_q;
        mem_tagchk    = tag_q;
        vr_we         = (state_q == S_WR1) || (state_q == S_WR2);
        vr_idx        = (state_q == S_WR2) ? dst1_q : dst0_q;
        sel_data      = (state_q == S_WR2) ? d2_q : d1_q;
        zero_data     = zero_q;
        done          = (state_q == S_FIN);
        flt_align     = fa_q;
        flt_undef     = fu_q;
    end
endmodule

// File: rtl/vpair_load_unit.sv
// Top of the paired vector load sequencer: address generation, sequencing
// FSM and write-data shaping. Assumes gpr_data answers gpr_idx in the same cycle.
module vpair_load_unit #(
    parameter int AW = 64,
    parameter int VW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    output logic          op_ready,
    input  logic [1:0]    op_size,
    input  logic [6:0]    op_imm7,
    input  logic [4:0]    op_base,
    input  logic [4:0]    op_dst0,
    input  logic [4:0]    op_dst1,
    input  logic [1:0]    cfg_same_dst,
    output logic [4:0]    gpr_idx,
    input  logic [AW-1:0] gpr_data,
    input  logic [AW-1:0] sp_value,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic          mem_nt,
    output logic          mem_tagchk,
    input  logic          mem_rsp_valid,
    input  logic [VW-1:0] mem_rsp_data,
    output logic          vr_we,
    output logic [4:0]    vr_idx,
    output logic [VW-1:0] vr_data,
    output logic          done,
    output logic          flt_align,
    output logic          flt_undef
);
    logic          base_is_sp, sp_mis, zero_data;
    logic [AW-1:0] addr_first, step_bytes;
    logic [VW-1:0] sel_data;

    assign gpr_idx = op_base;
    assign mem_nt  = 1'b1;

    vpl_addr_gen #(.AW(AW)) u_agen (
        .size(op_size), .imm(op_imm7), .base_idx(op_base),
        .gpr_val(gpr_data), .sp_val(sp_value),
        .base_is_sp(base_is_sp), .sp_misaligned(sp_mis),
        .addr_first(addr_first), .step_bytes(step_bytes)
    );

    vpl_ctrl #(.AW(AW), .VW(VW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_size(op_size),
        .op_dst0(op_dst0), .op_dst1(op_dst1), .cfg_same_dst(cfg_same_dst),
        .base_is_sp(base_is_sp), .sp_misaligned(sp_mis),
        .addr_first(addr_first), .step_bytes(step_bytes),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .op_ready(op_ready),
        .mem_req_valid(mem_req_valid), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_tagchk(mem_tagchk), .vr_we(vr_we),
        .vr_idx(vr_idx), .sel_data(sel_data), .zero_data(zero_data),
        .done(done), .flt_align(flt_align), .flt_undef(flt_undef)
    );

    vpl_wdata #(.VW(VW)) u_wdata (
        .size(mem_size), .force_zero(zero_data), .src(sel_data), .dst(vr_data)
    );
endmodule

// File: rtl/vpl_checker.sv
// Protocol checker for vpair_load_unit, attached by bind below.
module vpl_checker #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_ready,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_size,
    input logic          mem_nt,
    input logic          vr_we,
    input logic          done,
    input logic          flt_align,
    input logic          flt_undef
);
    AST_NT_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_nt); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)); // R9
    AST_NO_WRITE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        vr_we |-> !mem_req_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |-> !(mem_req_valid || vr_we || done)); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_FAULT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_align || flt_undef) |-> done); // R5
    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flt_align, flt_undef})); // R6
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_size != 2'b11); // R6
endmodule

bind vpair_load_unit vpl_checker #(.AW(AW)) u_vpl_checker (
    .clk(clk), .rst_n(rst_n), .op_ready(op_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_nt(mem_nt),
    .vr_we(vr_we), .done(done), .flt_align(flt_align), .flt_undef(flt_undef)
);

// File: tb/tb_vpair_load_unit.sv
// Scoreboard bench: the driver task queues expected requests, writes and
// completions; negedge monitors pop and compare them.
module tb_vpair_load_unit;
    logic         clk = 0, rst_n = 0;
    logic         op_valid = 0, op_ready;
    logic [1:0]   op_size = 0, cfg_same_dst = 0;
    logic [6:0]   op_imm7 = 0;
    logic [4:0]   op_base = 0, op_dst0 = 0, op_dst1 = 0, gpr_idx, vr_idx;
    logic [63:0]  gpr_data, sp_value = 0, mem_addr;
    logic         mem_req_valid, mem_req_ready = 0, mem_nt, mem_tagchk;
    logic [1:0]   mem_size;
    logic         mem_rsp_valid = 0;
    logic [127:0] mem_rsp_data = 0, vr_data;
    logic         vr_we, done, flt_align, flt_undef;

    int n_chk = 0, n_bad = 0, cyc = 0;

    logic [67:0]  q_req[$];  string q_req_t[$];
    logic [132:0] q_wr[$];   string q_wr_t[$];
    logic [1:0]   q_dn[$];   string q_dn_t[$];

    always #2 clk = ~clk;

    assign gpr_data = 64'h0000_4000_0000_0000 + {51'd0, gpr_idx, 8'h00};

    vpair_load_unit dut (.*);

    function automatic logic [127:0] memval(input logic [63:0] a);
        return {a ^ 64'hA5A5_5A5A_0F0F_F0F0, ~a + 64'h1234};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [132:0] act, input logic [132:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: compute expectations from the requirements, then issue
    task automatic issue(input logic [1:0] sz, input logic [6:0] imm, input logic [4:0] rn,
                         input logic [4:0] d0, input logic [4:0] d1, input logic [1:0] pol,
                         input string tag);
        int scale;
        logic [63:0] base, a1, a2, off;
        logic [127:0] mask, w1, w2;
        bit same, fu, fa, go;
        scale = 2 + int'(sz);
        base  = (rn == 5'd31) ? sp_value : 64'h0000_4000_0000_0000 + {51'd0, rn, 8'h00};
        off   = {{57{imm[6]}}, imm} << scale;
        a1    = base + off;
        a2    = a1 + (64'd1 << scale);
        mask  = (scale == 4) ? '1 : ((128'd1 << (8 << scale)) - 1);
        same  = (d0 == d1);
        fu = 0; fa = 0; go = 0;
        if (sz == 2'd3) fu = 1;
        else if (same && pol == 2'd1) fu = 1;
        else if (same && pol[1]) go = 0;
        else if (rn == 5'd31 && sp_value[3:0] != 0) fa = 1;
        else go = 1;
        if (go) begin
            q_req.push_back({sz, rn != 5'd31, 1'b1, a1}); q_req_t.push_back({tag, " first"});
            q_req.push_back({sz, rn != 5'd31, 1'b1, a2}); q_req_t.push_back({tag, " second"});
            w1 = same ? '0 : (memval(a1) & mask);
            w2 = same ? '0 : (memval(a2) & mask);
            q_wr.push_back({d0, w1}); q_wr_t.push_back({tag, " wr0"});
            q_wr.push_back({d1, w2}); q_wr_t.push_back({tag, " wr1"});
        end
        q_dn.push_back({fa, fu}); q_dn_t.push_back({tag, " done"});
        @(negedge clk);
        op_size = sz; op_imm7 = imm; op_base = rn; op_dst0 = d0; op_dst1 = d1;
        cfg_same_dst = pol; op_valid = 1;
        @(negedge clk);
        op_valid = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // Memory model with stalls; compares each accepted request
    logic        pend = 0;
    logic [63:0] pend_a = 0;
    always @(negedge clk) begin
        cyc++;
        if (mem_rsp_valid) mem_rsp_valid <= 0;
        if (pend) begin
            mem_rsp_valid <= 1; mem_rsp_data <= memval(pend_a); pend = 0;
        end
        mem_req_ready = rst_n && (cyc % 3 != 0);
        if (mem_req_valid && mem_req_ready) begin
            pend = 1; pend_a = mem_addr;
            if (q_req.size() == 0)
                check(0, "R5 R6 R7 unexpected request", {65'd0, mem_addr}, 133'd0);
            else begin
                logic [67:0] e; string t;
                e = q_req.pop_front(); t = q_req_t.pop_front();
                check({mem_size, mem_tagchk, mem_nt, mem_addr} == e,
                      {"R1 R2 R3 R4 R8 R9 request ", t},
                      {65'd0, mem_size, mem_tagchk, mem_nt, mem_addr}, {65'd0, e});
            end
        end
    end

    // Monitor for writes and completions
    always @(negedge clk) begin
        if (rst_n && vr_we) begin
            if (q_wr.size() == 0)
                check(0, "R5 R6 R7 unexpected write", {vr_idx, vr_data}, 133'd0);
            else begin
                logic [132:0] e; string t;
                e = q_wr.pop_front(); t = q_wr_t.pop_front();
                check({vr_idx, vr_data} == e, {"R1 R7 R9 write ", t}, {vr_idx, vr_data}, e);
            end
        end
        if (rst_n && done) begin
            if (q_dn.size() == 0)
                check(0, "R10 unexpected done", {131'd0, flt_align, flt_undef}, 133'd0);
            else begin
                logic [1:0] e; string t;
                e = q_dn.pop_front(); t = q_dn_t.pop_front();
                check({flt_align, flt_undef} == e, {"R5 R6 R10 done ", t},
                      {131'd0, flt_align, flt_undef}, {131'd0, e});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(op_ready && !mem_req_valid && !vr_we && !done, "R11 reset state",
              {129'd0, op_ready, mem_req_valid, vr_we, done}, {129'd0, 4'b1000});
        sp_value = 64'h0000_7FFF_FFF0_0000;
        issue(2'd0, 7'd5,        5'd3,  5'd1,  5'd2,  2'd0, "R1 R2 size4 +5");
        issue(2'd0, 7'h40,       5'd9,  5'd4,  5'd5,  2'd0, "R2 size4 min");
        issue(2'd1, 7'h40,       5'd7,  5'd6,  5'd8,  2'd0, "R2 size8 min");
        issue(2'd1, 7'h3F,       5'd0,  5'd10, 5'd11, 2'd0, "R2 size8 max");
        issue(2'd2, 7'h3F,       5'd31, 5'd12, 5'd13, 2'd0, "R4 R8 sp size16 max");
        issue(2'd2, 7'h7F,       5'd31, 5'd14, 5'd15, 2'd0, "R3 R4 sp size16 -1");
        issue(2'd2, 7'h40,       5'd30, 5'd16, 5'd0,  2'd0, "R2 size16 min");
        sp_value = 64'h0000_7FFF_FFF0_0008;
        issue(2'd1, 7'd2,        5'd31, 5'd1,  5'd2,  2'd0, "R5 misaligned sp");
        issue(2'd3, 7'd2,        5'd31, 5'd1,  5'd2,  2'd0, "R6 bad size over align");
        issue(2'd1, 7'd1,        5'd31, 5'd3,  5'd3,  2'd2, "R7 nop over align");
        issue(2'd3, 7'd1,        5'd4,  5'd3,  5'd3,  2'd2, "R6 bad size over same");
        issue(2'd0, 7'd1,        5'd4,  5'd3,  5'd5,  2'd0, "R8 tagchk gpr base");
        sp_value = 64'h0000_7FFF_FFF0_0000;
        issue(2'd1, 7'd3,        5'd5,  5'd7,  5'd7,  2'd0, "R7 zero policy");
        issue(2'd1, 7'd3,        5'd5,  5'd7,  5'd7,  2'd1, "R7 undef policy");
        issue(2'd2, 7'd3,        5'd31, 5'd9,  5'd9,  2'd3, "R7 nop policy");
        issue(2'd0, 7'h41,       5'd31, 5'd20, 5'd21, 2'd1, "R9 sp distinct");
        repeat (5) @(negedge clk);
        check(q_req.size() == 0 && q_wr.size() == 0 && q_dn.size() == 0,
              "R9 R10 all expected events seen",
              {101'd0, 32'(q_req.size() + q_wr.size() + q_dn.size())}, 133'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule